// File: doc/BRIEF.md
# Eight-Pin General-Purpose I/O Port Controller

This block is the digital control logic for one eight-pin general-purpose I/O port. A byte-wide register bus sets per-pin configuration. For each pin the block picks the output value, either from a port data register or from a signal supplied by the on-chip logic fabric. It then turns a three-bit drive mode into pad control signals: strong-drive enable, pull-up enable, pull-down enable and analog connect. In the other direction it reduces the pad input to a readable pin-state byte, which also goes back to the fabric.

Each pin can be switched on its own between several behaviours. The output can come from the data register or from the fabric. The output enable can be constant or follow the fabric. The input can be passed through a two-flop synchroniser or left unsynchronised, and the output can be registered or left combinational. The input buffer can be switched off. A masked write path lets software change a subset of the data bits without a read-modify-write. The state loaded at reset is chosen by a two-bit input.

The analog pad itself, the voltage thresholds and the drive strengths are outside this block. It only produces the control signals for the pad.

Top module: `gpio_port_ctrl`

## Requirements
- R1: With reset drive select 00, reset leaves every register at zero. Every pin is then in analog high-impedance mode: pad_ana=FF, pad_oe=00, pad_pu=00, pad_pd=00, fab_in=00, and the drive-mode registers read 00.
- R2: A write with bus_we high stores bus_wdata in the register at bus_addr at that clock edge. bus_rdata presents the register selected by bus_addr one clock later. Register addresses: 0 data, 1 masked data, 2 mask, 3 bypass, 4 bidirectional enable, 5 input disable, 6 input sync, 7 output sync, 8 mode bit 0, 9 mode bit 1, 10 mode bit 2, 11 pin state (read only).
- R3: A pin whose bypass bit is 1 takes its output value from fab_out. A pin whose bypass bit is 0 takes it from the data register.
- R4: A pin whose bidirectional-enable bit is 1 uses fab_out_en as its output enable. Otherwise its output enable is constantly 1.
- R5: The mode code is {mode bit 2, mode bit 1, mode bit 0}, and pad_oe is always gated by the output enable of R4. Each code behaves as follows:
  - 000: analog; no drive and no pulls.
  - 001: no drive and no pulls.
  - 010: drives when the value is 0; pull-up on.
  - 011: drives when the value is 1; pull-down on.
  - 100: drives when the value is 0.
  - 101: drives when the value is 1.
  - 110: always drives.
  - 111: no drive; pull-up when the value is 1, pull-down when it is 0.
- R6: A pin in mode 000 asserts pad_ana, and its pin-state bit reads 0 whatever pad_in is.
- R7: A pin whose input-disable bit is 1 reads 0 in the pin state. Otherwise the pin state follows pad_in.
- R8: A pin whose input-sync bit is 1 shows a pad_in change in its pin state two clocks later. With the bit at 0 the change shows at once.
- R9: A pin whose output-sync bit is 1 shows a change of its selected value on pad_out one clock later. With the bit at 0 the change shows at once.
- R10: A write to the masked data address changes only the data bits whose mask bit is 1.
- R11: The reset drive select picks the state loaded at reset:
  - 00: analog (mode 000, data 00).
  - 01: pull-up (mode 010, data FF).
  - 10: pull-down (mode 011, data 00).
  - 11: digital high impedance (mode 001, data 00).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and port clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rst_dm | input | 2 | Reset state select |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Single-cycle write strobe |
| bus_rdata | output | 8 | Registered read data |
| fab_out | input | 8 | Fabric output value per pin |
| fab_out_en | input | 8 | Fabric output enable per pin |
| fab_in | output | 8 | Pin state toward the fabric |
| pad_in | input | 8 | Pad input level |
| pad_out | output | 8 | Value driven to the pad |
| pad_oe | output | 8 | Strong drive enable |
| pad_pu | output | 8 | Pull-up enable |
| pad_pd | output | 8 | Pull-down enable |
| pad_ana | output | 8 | Analog connect enable |

## Verification
A corrupted configuration bit shows up on the pad control outputs in the same cycle, because the drive decode is purely combinational after the registers. The register readback exposes the same fault one clock later. A synchroniser or output-register fault appears as a one-cycle shift in when pad_in changes reach fab_in, or when data changes reach pad_out. Checks sampled in each of the cycles around such a change catch a stage that is too many or missing. Masked writes are checked by observing pad_out and reading the data register back, so a leaked bit outside the mask is seen within one cycle.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
    localparam int NPIN = 8;
    localparam int AW   = 4;

    typedef enum logic [2:0] {
        DM_ANALOG    = 3'b000,
        DM_DIG_HIZ   = 3'b001,
        DM_PULL_UP   = 3'b010,
        DM_PULL_DN   = 3'b011,
        DM_OD_LOW    = 3'b100,
        DM_OD_HIGH   = 3'b101,
        DM_STRONG    = 3'b110,
        DM_PULL_BOTH = 3'b111
    } drv_mode_e;

    localparam logic [AW-1:0] A_DATA     = 4'd0;
    localparam logic [AW-1:0] A_DATA_MSK = 4'd1;
    localparam logic [AW-1:0] A_MASK     = 4'd2;
    localparam logic [AW-1:0] A_BYP      = 4'd3;
    localparam logic [AW-1:0] A_BIDIR    = 4'd4;
    localparam logic [AW-1:0] A_INDIS    = 4'd5;
    localparam logic [AW-1:0] A_ISYNC    = 4'd6;
    localparam logic [AW-1:0] A_OSYNC    = 4'd7;
    localparam logic [AW-1:0] A_DM0      = 4'd8;
    localparam logic [AW-1:0] A_DM1      = 4'd9;
    localparam logic [AW-1:0] A_DM2      = 4'd10;
    localparam logic [AW-1:0] A_STATE    = 4'd11;

    typedef struct packed {
        logic [NPIN-1:0] data;
        logic [NPIN-1:0] mask;
        logic [NPIN-1:0] byp;
        logic [NPIN-1:0] bidir;
        logic [NPIN-1:0] indis;
        logic [NPIN-1:0] isync;
        logic [NPIN-1:0] osync;
        logic [NPIN-1:0] dm0;
        logic [NPIN-1:0] dm1;
        logic [NPIN-1:0] dm2;
    } port_cfg_t;

    function automatic port_cfg_t cfg_reset(input logic [1:0] sel);
        port_cfg_t c;
        c = '0;
        case (sel)
            2'b01: begin
                c.dm1  = '1;
                c.data = '1;
            end
            2'b10: begin
                c.dm1 = '1;
                c.dm0 = '1;
            end
            2'b11: c.dm0 = '1;
            default: ;
        endcase
        return c;
    endfunction
endpackage

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
    import gpio_port_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      rst_dm,
    input  logic [AW-1:0]   bus_addr,
    input  logic [NPIN-1:0] bus_wdata,
    input  logic            bus_we,
    input  logic [NPIN-1:0] pin_state,
    output logic [NPIN-1:0] bus_rdata,
    output port_cfg_t       cfg
);
    typedef struct packed {
        port_cfg_t       cfg;
        logic [NPIN-1:0] rdata;
    } regs_t;

    regs_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        case (bus_addr)
            A_DATA:     s_d.rdata = s_q.cfg.data;
            A_DATA_MSK: s_d.rdata = s_q.cfg.data;
            A_MASK:     s_d.rdata = s_q.cfg.mask;
            A_BYP:      s_d.rdata = s_q.cfg.byp;
            A_BIDIR:    s_d.rdata = s_q.cfg.bidir;
            A_INDIS:    s_d.rdata = s_q.cfg.indis;
            A_ISYNC:    s_d.rdata = s_q.cfg.isync;
            A_OSYNC:    s_d.rdata = s_q.cfg.osync;
            A_DM0:      s_d.rdata = s_q.cfg.dm0;
            A_DM1:      s_d.rdata = s_q.cfg.dm1;
            A_DM2:      s_d.rdata = s_q.cfg.dm2;
            A_STATE:    s_d.rdata = pin_state;
            default:    s_d.rdata = '0;
        endcase
        if (bus_we) begin
            case (bus_addr)
                A_DATA:     s_d.cfg.data  = bus_wdata;
                A_DATA_MSK: s_d.cfg.data  = (s_q.cfg.data & ~s_q.cfg.mask)
                                          | (bus_wdata & s_q.cfg.mask);
                A_MASK:     s_d.cfg.mask  = bus_wdata;
                A_BYP:      s_d.cfg.byp   = bus_wdata;
                A_BIDIR:    s_d.cfg.bidir = bus_wdata;
                A_INDIS:    s_d.cfg.indis = bus_wdata;
                A_ISYNC:    s_d.cfg.isync = bus_wdata;
                A_OSYNC:    s_d.cfg.osync = bus_wdata;
                A_DM0:      s_d.cfg.dm0   = bus_wdata;
                A_DM1:      s_d.cfg.dm1   = bus_wdata;
                A_DM2:      s_d.cfg.dm2   = bus_wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.cfg   <= cfg_reset(rst_dm);
            s_q.rdata <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cfg       = s_q.cfg;
    assign bus_rdata = s_q.rdata;

    // R10: a masked write leaves every unmasked data bit unchanged
    p_mask_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_we && (bus_addr == A_DATA_MSK))
        |-> (((cfg.data ^ $past(cfg.data)) & ~$past(cfg.mask)) == '0));

    // R2: a plain data write lands exactly
    p_write_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_we && (bus_addr == A_DATA)) |-> (cfg.data == $past(bus_wdata)));
endmodule

// File: rtl/gpio_pin_slice.sv
module gpio_pin_slice
    import gpio_port_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       data,
    input  logic       byp,
    input  logic       bidir,
    input  logic       indis,
    input  logic       isync,
    input  logic       osync,
    input  logic [2:0] dm,
    input  logic       fab_out,
    input  logic       fab_oe,
    input  logic       pad_in,
    output logic       pad_out,
    output logic       pad_oe,
    output logic       pad_pu,
    output logic       pad_pd,
    output logic       pad_ana,
    output logic       pin_state
);
    typedef struct packed {
        logic sy1;
        logic sy2;
        logic oreg;
    } slice_t;

    slice_t    s_d, s_q;
    logic      val_sel, val, oe_eff, drive, in_val;
    drv_mode_e mode;

    assign mode    = drv_mode_e'(dm);
    assign val_sel = byp ? fab_out : data;
    assign val     = osync ? s_q.oreg : val_sel;
    assign oe_eff  = bidir ? fab_oe : 1'b1;

    always_comb begin
        s_d      = s_q;
        s_d.sy1  = pad_in;
        s_d.sy2  = s_q.sy1;
        s_d.oreg = val_sel;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        drive  = 1'b0;
        pad_pu = 1'b0;
        pad_pd = 1'b0;
        case (mode)
            DM_PULL_UP: begin
                drive  = ~val;
                pad_pu = 1'b1;
            end
            DM_PULL_DN: begin
                drive  = val;
                pad_pd = 1'b1;
            end
            DM_OD_LOW:  drive = ~val;
            DM_OD_HIGH: drive = val;
            DM_STRONG:  drive = 1'b1;
            DM_PULL_BOTH: begin
                pad_pu = val;
                pad_pd = ~val;
            end
            default: ;
        endcase
    end

    assign pad_out   = val;
    assign pad_oe    = oe_eff & drive;
    assign pad_ana   = (mode == DM_ANALOG);
    assign in_val    = isync ? s_q.sy2 : pad_in;
    assign pin_state = (indis || pad_ana) ? 1'b0 : in_val;

    logic [1:0] warm_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             warm_q <= 2'd0;
        else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
    end

    // R6: analog mode never drives or pulls and reads 0
    p_ana_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pad_ana |-> (!pad_oe && !pad_pu && !pad_pd && !pin_state));

    // R8: synchronised input lags the pad by two clocks
    p_in_sync_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q >= 2'd2 && isync && !indis && !pad_ana) |-> (pin_state == $past(pad_in, 2)));

    // R9: registered output lags the selected value by one clock
    p_out_sync_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q >= 2'd1 && osync) |-> (pad_out == $past(val_sel)));

    // R4: in always-drive mode the fabric enable governs the pad enable
    p_bidir_strong_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bidir && mode == DM_STRONG) |-> (pad_oe == fab_oe));
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
    import gpio_port_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      rst_dm,
    input  logic [AW-1:0]   bus_addr,
    input  logic [NPIN-1:0] bus_wdata,
    input  logic            bus_we,
    output logic [NPIN-1:0] bus_rdata,
    input  logic [NPIN-1:0] fab_out,
    input  logic [NPIN-1:0] fab_out_en,
    output logic [NPIN-1:0] fab_in,
    input  logic [NPIN-1:0] pad_in,
    output logic [NPIN-1:0] pad_out,
    output logic [NPIN-1:0] pad_oe,
    output logic [NPIN-1:0] pad_pu,
    output logic [NPIN-1:0] pad_pd,
    output logic [NPIN-1:0] pad_ana
);
    port_cfg_t       cfg;
    logic [NPIN-1:0] pin_state;

    gpio_port_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .rst_dm    (rst_dm),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_we    (bus_we),
        .pin_state (pin_state),
        .bus_rdata (bus_rdata),
        .cfg       (cfg)
    );

    for (genvar i = 0; i < NPIN; i++) begin : g_pin
        gpio_pin_slice u_slice (
            .clk       (clk),
            .rst_n     (rst_n),
            .data      (cfg.data[i]),
            .byp       (cfg.byp[i]),
            .bidir     (cfg.bidir[i]),
            .indis     (cfg.indis[i]),
            .isync     (cfg.isync[i]),
            .osync     (cfg.osync[i]),
            .dm        ({cfg.dm2[i], cfg.dm1[i], cfg.dm0[i]}),
            .fab_out   (fab_out[i]),
            .fab_oe    (fab_out_en[i]),
            .pad_in    (pad_in[i]),
            .pad_out   (pad_out[i]),
            .pad_oe    (pad_oe[i]),
            .pad_pu    (pad_pu[i]),
            .pad_pd    (pad_pd[i]),
            .pad_ana   (pad_ana[i]),
            .pin_state (pin_state[i])
        );
    end

    assign fab_in = pin_state;

    // R7: a disabled input never reports a high pin
    p_indis_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fab_in & cfg.indis) == '0);

    // R2: the readback of the pin-state address follows fab_in by one clock
    p_state_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_addr == A_STATE) |-> (bus_rdata == $past(fab_in)));

    // R1: pins that are not drive-capable in analog mode stay released
    p_ana_oe_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & pad_ana) == '0);
endmodule

// File: tb/gpio_port_ctrl_test.sv
module gpio_port_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] rst_dm = 2'b00;
    logic [3:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_rdata, fab_in, pad_out, pad_oe, pad_pu, pad_pd, pad_ana;
    logic [7:0] fab_out = '0, fab_out_en = '0, pad_in = '0;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    typedef struct {
        string      req;
        int         src;
        logic [7:0] exp;
    } exp_t;
    exp_t expq[$];

    always #2 clk = ~clk;

    gpio_port_ctrl uut (
        .clk(clk), .rst_n(rst_n), .rst_dm(rst_dm),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we),
        .bus_rdata(bus_rdata), .fab_out(fab_out), .fab_out_en(fab_out_en),
        .fab_in(fab_in), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
        .pad_pu(pad_pu), .pad_pd(pad_pd), .pad_ana(pad_ana)
    );

    // output selectors for the scoreboard
    localparam int S_OUT = 0, S_OE = 1, S_PU = 2, S_PD = 3, S_ANA = 4, S_IN = 5, S_RD = 6;

    function automatic logic [7:0] pick(input int src);
        case (src)
            S_OUT:   return pad_out;
            S_OE:    return pad_oe;
            S_PU:    return pad_pu;
            S_PD:    return pad_pd;
            S_ANA:   return pad_ana;
            S_IN:    return fab_in;
            default: return bus_rdata;
        endcase
    endfunction

    // monitor: compares queued expectations mid-cycle
    initial begin
        forever begin
            @(negedge clk);
            while (expq.size() > 0) begin
                exp_t e;
                logic [7:0] act;
                e = expq.pop_front();
                act = pick(e.src);
                vectors++;
                if (act !== e.exp) begin
                    miscompares++;
                    $display("FAIL %s src=%0d actual=%02h expected=%02h", e.req, e.src, act, e.exp);
                end
            end
        end
    end

    task automatic expect_v(input string req, input int src, input logic [7:0] v);
        exp_t e;
        e.req = req; e.src = src; e.exp = v;
        expq.push_back(e);
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        step();
        bus_we = 1'b0;
    endtask

    task automatic rd_expect(input string req, input logic [3:0] a, input logic [7:0] v);
        bus_addr = a;
        step();
        expect_v(req, S_RD, v);
        step();
    endtask

    task automatic do_reset(input logic [1:0] sel);
        rst_n = 1'b0; rst_dm = sel;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        step();
    endtask

    function automatic logic [2:0] model(input logic [2:0] m, input logic v);
        // returns {drive, pull-up, pull-down} per R5
        case (m)
            3'b010:  return {~v, 1'b1, 1'b0};
            3'b011:  return {v, 1'b0, 1'b1};
            3'b100:  return {~v, 1'b0, 1'b0};
            3'b101:  return {v, 1'b0, 1'b0};
            3'b110:  return {1'b1, 1'b0, 1'b0};
            3'b111:  return {1'b0, v, ~v};
            default: return 3'b000;
        endcase
    endfunction

    initial begin
        #800000;
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        pad_in = 8'hA5;
        do_reset(2'b00);
        // R1 reset state
        expect_v("R1", S_ANA, 8'hFF);
        expect_v("R1", S_OE, 8'h00);
        expect_v("R1", S_PU, 8'h00);
        expect_v("R1", S_PD, 8'h00);
        expect_v("R1", S_IN, 8'h00);
        step();
        rd_expect("R1", 4'd8, 8'h00);
        // R6 analog reads zero through bus
        rd_expect("R6", 4'd11, 8'h00);

        // R2 register write/read
        wr(4'd0, 8'h3C);
        rd_expect("R2", 4'd0, 8'h3C);
        wr(4'd2, 8'h0F);
        rd_expect("R2", 4'd2, 8'h0F);

        // R5 strong mode on all pins
        wr(4'd9, 8'hFF);
        wr(4'd10, 8'hFF);
        expect_v("R5", S_OE, 8'hFF);
        expect_v("R5", S_OUT, 8'h3C);
        expect_v("R6", S_ANA, 8'h00);
        step();

        // R10 masked write
        wr(4'd1, 8'hFF);
        expect_v("R10", S_OUT, 8'h3F);
        step();
        wr(4'd1, 8'h00);
        wr(4'd2, 8'hF0);
        wr(4'd1, 8'h5A);
        rd_expect("R10", 4'd0, 8'h50);
        wr(4'd0, 8'h3F);

        // R3 bypass
        fab_out = 8'h55;
        wr(4'd3, 8'hF0);
        expect_v("R3", S_OUT, 8'h5F);
        step();

        // R4 bidirectional enable
        fab_out_en = 8'h03;
        wr(4'd4, 8'h0F);
        expect_v("R4", S_OE, 8'hF3);
        step();
        fab_out_en = 8'h0C;
        expect_v("R4", S_OE, 8'hFC);
        step();
        wr(4'd4, 8'h00);

        // R7 input path and disable
        expect_v("R7", S_IN, 8'hA5);
        step();
        wr(4'd5, 8'h80);
        wr(4'd9, 8'hFE);
        wr(4'd10, 8'hFE);
        expect_v("R7", S_IN, 8'h24);
        expect_v("R6", S_ANA, 8'h01);
        expect_v("R6", S_OE, 8'hFE);
        step();
        rd_expect("R7", 4'd11, 8'h24);
        wr(4'd9, 8'hFF);
        wr(4'd10, 8'hFF);
        wr(4'd5, 8'h00);

        // R8 input synchroniser latency
        wr(4'd6, 8'hFF);
        step();
        pad_in = 8'h5A;
        expect_v("R8", S_IN, 8'hA5);
        step();
        expect_v("R8", S_IN, 8'hA5);
        step();
        expect_v("R8", S_IN, 8'h5A);
        step();
        wr(4'd6, 8'h00);
        pad_in = 8'h0F;
        expect_v("R8", S_IN, 8'h0F);
        step();

        // R9 output register latency
        wr(4'd7, 8'hFF);
        expect_v("R9", S_OUT, 8'h5F);
        step();
        wr(4'd0, 8'h00);
        expect_v("R9", S_OUT, 8'h5F);
        step();
        expect_v("R9", S_OUT, 8'h50);
        fab_out = 8'hAA;
        expect_v("R9", S_OUT, 8'h50);
        step();
        expect_v("R9", S_OUT, 8'hA0);
        step();
        wr(4'd7, 8'h00);
        wr(4'd3, 8'h00);

        // R5 full drive table, data 0F
        wr(4'd0, 8'h0F);
        for (int m = 0; m < 8; m++) begin
            logic [7:0] eo, eu, ed;
            logic [2:0] mm;
            mm = 3'(m);
            wr(4'd8, {8{mm[0]}});
            wr(4'd9, {8{mm[1]}});
            wr(4'd10, {8{mm[2]}});
            for (int b = 0; b < 8; b++) begin
                logic [2:0] r;
                r = model(mm, (b < 4));
                eo[b] = r[2]; eu[b] = r[1]; ed[b] = r[0];
            end
            expect_v("R5", S_OE, eo);
            expect_v("R5", S_PU, eu);
            expect_v("R5", S_PD, ed);
            expect_v("R5", S_ANA, (mm == 3'b000) ? 8'hFF : 8'h00);
            step();
        end

        // R11 reset select variants
        do_reset(2'b01);
        expect_v("R11", S_PU, 8'hFF);
        expect_v("R11", S_OE, 8'h00);
        expect_v("R11", S_OUT, 8'hFF);
        expect_v("R11", S_ANA, 8'h00);
        step();
        rd_expect("R11", 4'd9, 8'hFF);
        do_reset(2'b10);
        expect_v("R11", S_PD, 8'hFF);
        expect_v("R11", S_OE, 8'h00);
        step();
        pad_in = 8'hA5;
        do_reset(2'b11);
        expect_v("R11", S_IN, 8'hA5);
        expect_v("R11", S_OE, 8'h00);
        expect_v("R11", S_PU, 8'h00);
        expect_v("R11", S_ANA, 8'h00);
        step();
        step();

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule